// File: doc/BRIEF.md
# Video Output Formatter with Range Clipping

This block sits at the end of a camera colour pipeline. It accepts one luma/chroma sample pair per pixel slot and presents it on two 10-bit output channels, together with an output clock for the receiver. In parallel mode channel A carries luma and channel B carries chroma, one pixel per output clock. In interleaved mode both components share channel A at twice that word rate, chroma word first and luma word second. This follows the Cb Y Cr Y order of a 4:2:2 stream when the upstream source alternates Cb and Cr. Output data changes only on the falling edge of the output clock, so a receiver can latch on the rising edge.

Every video word passes a clipper that compares its 8 most significant bits with limits. The limits are either the legal video ranges or a wide range that only keeps out the two reserved codes 00h and FFh. Timing reference words, which are made upstream, are marked with a bypass flag and pass through unchanged. The core clock `clk` runs at four times the pixel rate. A pixel slot is four `clk` cycles long.

The input is a valid/ready stream. `in_ready` is high for one cycle in every four. A pair moves when `in_valid` and `in_ready` are both high on a rising edge. The producer must hold its pair and its flags steady until that happens. The output side has no back-pressure. A slot that receives no pair sends blanking values.

Top module: `vf_out_fmt`

## Requirements
- R1: While `rst` is high: `out_a` = 040h, `out_b` = 200h, `out_clk` = 0 and `in_ready` = 0.
- R2: `in_ready` is high in exactly one cycle of every four (cycle 3, 7, 11, … after reset is released). A pair accepted at that edge appears on the outputs from the very next cycle.
- R3: With `par_mode` = 1, `out_a` holds the processed luma and `out_b` holds the processed chroma for the four cycles of the slot.
- R4: With `par_mode` = 0, `out_a` holds the processed chroma for two cycles, then the processed luma for two cycles. During that slot `out_b` is 000h.
- R5: `out_clk` is low for cycles 0–1 and high for cycles 2–3 of a slot in parallel mode. It is low, high, low, high in interleaved mode. `out_a` and `out_b` change only on edges where `out_clk` falls.
- R6: With `clip_off` = 0, a luma word whose upper 8 bits (bits 9:2) are below 16 becomes 040h. One whose upper bits are above 235 becomes 3ACh.
- R7: With `clip_off` = 0, a chroma word whose bits 9:2 are below 16 becomes 040h. One whose bits 9:2 are above 240 becomes 3C0h.
- R8: With `clip_off` = 1, both components are limited to bits 9:2 in 1..254. A clamped value becomes 004h or 3F8h.
- R9: A clamped word has its two low bits forced to 00. A word inside the limits keeps all ten bits, including values at a limit with non-zero low bits.
- R10: A pair accepted with `in_code` = 1 passes both components out unchanged, whatever their value.
- R11: In parallel mode `out_b` is 200h for a slot whose accepted pair has `in_c_valid` = 0.
- R12: A slot in which no pair is accepted sends luma 040h and chroma 200h.
- R13: `par_mode` and `clip_off` are sampled at the accepting edge (cycle 3 of the slot). Changing them between slots switches the format cleanly at the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| par_mode | input | 1 | 1 = parallel two-channel output, 0 = interleaved on channel A |
| clip_off | input | 1 | 1 = wide 1..254 limits, 0 = legal video limits |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block takes a pair on this edge |
| in_y | input | 10 | Luma sample, 8 integer and 2 fractional bits |
| in_c | input | 10 | Chroma sample (Cb or Cr) |
| in_c_valid | input | 1 | Chroma sample carries data |
| in_code | input | 1 | Pair is a timing reference word, so clipping is skipped |
| out_clk | output | 1 | Output clock; data changes on its falling edge |
| out_a | output | 10 | Channel A: luma, or interleaved chroma/luma |
| out_b | output | 10 | Channel B: chroma in parallel mode, 000h otherwise |

## Verification
The formatter is driven in both modes with several kinds of input. Mid-range values show that words inside the limits pass with all ten bits kept. Sweeps of the full 10-bit range with each clip setting show where each component's lower and upper limit lies, and that luma and chroma have different upper limits. Flagged timing words, invalid chroma and empty slots show the three ways a word can skip normal processing. Mode and clip changes between consecutive pixels show that a setting takes effect at a slot edge and never in the middle of a slot.

// File: rtl/vfo_pkg.sv
package vfo_pkg;
  // Sample format: 8 integer bits, 2 fractional bits.
  localparam int SAMPLE_W = 10;
  localparam int FRAC_W   = 2;
  localparam int INT_W    = SAMPLE_W - FRAC_W;

  // Pixel slot of four core cycles.
  localparam int SLOT_CYC = 4;
  localparam int PH_W     = $clog2(SLOT_CYC);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(SLOT_CYC / 2 - 1);

  // Limits on the integer part of a sample.
  localparam logic [INT_W-1:0] LEGAL_LO  = 8'd16;
  localparam logic [INT_W-1:0] LUMA_HI   = 8'd235;
  localparam logic [INT_W-1:0] CHROMA_HI = 8'd240;
  localparam logic [INT_W-1:0] WIDE_LO   = 8'd1;
  localparam logic [INT_W-1:0] WIDE_HI   = 8'd254;

  // Blanking words.
  localparam logic [SAMPLE_W-1:0] BLANK_Y = {8'h10, {FRAC_W{1'b0}}};
  localparam logic [SAMPLE_W-1:0] BLANK_C = {8'h80, {FRAC_W{1'b0}}};

  typedef enum logic {
    FMT_INTERLEAVED = 1'b0,
    FMT_PARALLEL    = 1'b1
  } fmt_e;

  function automatic logic [SAMPLE_W-1:0] clamp_word(
    input logic [SAMPLE_W-1:0] x,
    input logic [INT_W-1:0]    lo,
    input logic [INT_W-1:0]    hi
  );
    logic [INT_W-1:0] ip;
    ip = x[SAMPLE_W-1:FRAC_W];
    if (ip < lo)      return {lo, {FRAC_W{1'b0}}};
    else if (ip > hi) return {hi, {FRAC_W{1'b0}}};
    else              return x;
  endfunction
endpackage

// File: rtl/fmt_phase.sv
module fmt_phase
  import vfo_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_next,
  output logic            slot_last
);
  always_comb begin
    ph_next   = ph + PH_W'(1);
    slot_last = (ph == PH_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph_next;
  end
endmodule

// File: rtl/fmt_clip.sv
module fmt_clip
  import vfo_pkg::*;
#(
  parameter bit IS_LUMA = 1'b1
) (
  input  logic [SAMPLE_W-1:0] din,
  input  logic                wide,
  input  logic                bypass,
  output logic [SAMPLE_W-1:0] dout
);
  logic [INT_W-1:0] legal_hi;

  generate
    if (IS_LUMA) begin : g_luma
      assign legal_hi = LUMA_HI;
    end else begin : g_chroma
      assign legal_hi = CHROMA_HI;
    end
  endgenerate

  always_comb begin
    if (bypass)
      dout = din;
    else if (wide)
      dout = clamp_word(din, WIDE_LO, WIDE_HI);
    else
      dout = clamp_word(din, LEGAL_LO, legal_hi);
  end
endmodule

// File: rtl/fmt_drive.sv
module fmt_drive
  import vfo_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [PH_W-1:0]     ph,
  input  logic [PH_W-1:0]     ph_next,
  input  logic                slot_last,
  input  logic                par_mode,
  input  logic                take,
  input  logic                c_valid,
  input  logic [SAMPLE_W-1:0] y_proc,
  input  logic [SAMPLE_W-1:0] c_proc,
  output logic                out_clk,
  output logic [SAMPLE_W-1:0] out_a,
  output logic [SAMPLE_W-1:0] out_b
);
  fmt_e                fmt_q, fmt_n;
  logic [SAMPLE_W-1:0] y_hold;
  logic [SAMPLE_W-1:0] y_sel, c_sel, b_par;
  logic                clk_n;

  always_comb begin
    fmt_n = slot_last ? fmt_e'(par_mode) : fmt_q;
    y_sel = take ? y_proc : BLANK_Y;
    c_sel = take ? c_proc : BLANK_C;
    b_par = (take && c_valid) ? c_proc : BLANK_C;
    // Half-rate clock in parallel mode, word-rate clock in interleaved mode.
    if (fmt_n == FMT_PARALLEL) clk_n = ph_next[PH_W-1];
    else                       clk_n = ph_next[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q   <= FMT_PARALLEL;
      y_hold  <= BLANK_Y;
      out_a   <= BLANK_Y;
      out_b   <= BLANK_C;
      out_clk <= 1'b0;
    end else begin
      out_clk <= clk_n;
      if (slot_last) begin
        fmt_q  <= fmt_e'(par_mode);
        y_hold <= y_sel;
        if (fmt_e'(par_mode) == FMT_PARALLEL) begin
          out_a <= y_sel;
          out_b <= b_par;
        end else begin
          out_a <= c_sel;
          out_b <= '0;
        end
      end else if (ph == PH_HALF && fmt_q == FMT_INTERLEAVED) begin
        out_a <= y_hold;
      end
    end
  end
endmodule

// File: rtl/vf_out_fmt.sv
module vf_out_fmt
  import vfo_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                par_mode,
  input  logic                clip_off,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_y,
  input  logic [SAMPLE_W-1:0] in_c,
  input  logic                in_c_valid,
  input  logic                in_code,
  output logic                out_clk,
  output logic [SAMPLE_W-1:0] out_a,
  output logic [SAMPLE_W-1:0] out_b
);
  logic [PH_W-1:0]     ph, ph_next;
  logic                slot_last;
  logic                take;
  logic [SAMPLE_W-1:0] comp_in  [2];
  logic [SAMPLE_W-1:0] comp_out [2];

  fmt_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .ph_next   (ph_next),
    .slot_last (slot_last)
  );

  assign in_ready   = slot_last && !rst;
  assign take       = in_valid && in_ready;
  assign comp_in[0] = in_y;
  assign comp_in[1] = in_c;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_comp
      fmt_clip #(.IS_LUMA(g == 0)) u_clip (
        .din    (comp_in[g]),
        .wide   (clip_off),
        .bypass (in_code),
        .dout   (comp_out[g])
      );
    end
  endgenerate

  fmt_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .ph_next   (ph_next),
    .slot_last (slot_last),
    .par_mode  (par_mode),
    .take      (take),
    .c_valid   (in_c_valid),
    .y_proc    (comp_out[0]),
    .c_proc    (comp_out[1]),
    .out_clk   (out_clk),
    .out_a     (out_a),
    .out_b     (out_b)
  );
endmodule

// File: rtl/vfo_chk.sv
module vfo_chk (
  input logic       clk,
  input logic       rst,
  input logic       par_mode,
  input logic       clip_off,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_c_valid,
  input logic       in_code,
  input logic       out_clk,
  input logic [9:0] out_a,
  input logic [9:0] out_b
);
  // R2: a slot offers exactly one accepting cycle, never two in a row
  p_single_take_r2: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R5: output words move only on a falling output clock
  p_change_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(out_a) || !$stable(out_b)) |-> $fell(out_clk));

  // R6: legal luma range in parallel mode
  p_legal_luma_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && !in_code && par_mode && !clip_off)
      |=> (out_a[9:2] >= 8'd16 && out_a[9:2] <= 8'd235));

  // R8: reserved codes never leave on a clipped word
  p_no_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && !in_code && par_mode)
      |=> (out_a[9:2] != 8'h00 && out_a[9:2] != 8'hFF));

  // R11: missing chroma gives the neutral value on channel B
  p_neutral_chroma_r11: assert property (@(posedge clk) disable iff (rst)
    (in_ready && par_mode && !(in_valid && in_c_valid)) |=> (out_b == 10'h200));

  // R4: channel B is idle in interleaved mode
  p_b_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !par_mode) |=> (out_b == 10'h000));
endmodule

bind vf_out_fmt vfo_chk u_vfo_chk (
  .clk        (clk),
  .rst        (rst),
  .par_mode   (par_mode),
  .clip_off   (clip_off),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_c_valid (in_c_valid),
  .in_code    (in_code),
  .out_clk    (out_clk),
  .out_a      (out_a),
  .out_b      (out_b)
);

// File: tb/test_vf_out_fmt.sv
module test_vf_out_fmt;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_mode = 1'b1;
  logic       clip_off = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_y = '0;
  logic [9:0] in_c = '0;
  logic       in_c_valid = 1'b0;
  logic       in_code = 1'b0;
  logic       out_clk;
  logic [9:0] out_a, out_b;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string cur_req = "R3";

  // Reference model state
  int m_ph, m_a, m_b, m_clk, m_yh;
  bit m_par;

  always #(CLK_PERIOD/2) clk = ~clk;

  vf_out_fmt i_vf_out_fmt (
    .clk(clk), .rst(rst), .par_mode(par_mode), .clip_off(clip_off),
    .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y), .in_c(in_c),
    .in_c_valid(in_c_valid), .in_code(in_code), .out_clk(out_clk),
    .out_a(out_a), .out_b(out_b)
  );

  function automatic int ref_clip(int x, bit luma, bit wide, bit code);
    int m, lo, hi;
    if (code) return x;
    m  = x / 4;
    lo = wide ? 1 : 16;
    hi = wide ? 254 : (luma ? 235 : 240);
    if (m < lo) return lo * 4;
    if (m > hi) return hi * 4;
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_a = 'h040; m_b = 'h200; m_clk = 0; m_yh = 'h040; m_par = 1;
    end else begin
      if (m_ph == 3) begin
        int y, c;
        bit acc;
        acc   = in_valid;
        m_par = par_mode;
        y = acc ? ref_clip(in_y, 1, clip_off, in_code) : 'h040;
        c = acc ? ref_clip(in_c, 0, clip_off, in_code) : 'h200;
        if (m_par) begin
          m_a = y;
          m_b = (acc && in_c_valid) ? c : 'h200;
        end else begin
          m_a = c;
          m_b = 0;
          m_yh = y;
        end
      end else if (m_ph == 1 && !m_par) begin
        m_a = m_yh;
      end
      m_ph  = (m_ph + 1) % 4;
      m_clk = m_par ? (m_ph >= 2) : (m_ph % 2);
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst) begin
      n_run++;
      if (out_a !== 10'h040 || out_b !== 10'h200 || out_clk !== 1'b0 || in_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 reset: a=%h b=%h clk=%b rdy=%b exp a=040 b=200 clk=0 rdy=0",
                 out_a, out_b, out_clk, in_ready);
      end
    end else if (!done) begin
      n_run++;
      if (in_ready !== (m_ph == 3)) begin
        n_fail++;
        $display("FAIL R2 in_ready=%b exp=%b", in_ready, (m_ph == 3));
      end else if (out_clk !== m_clk[0]) begin
        n_fail++;
        $display("FAIL R5 out_clk=%b exp=%b", out_clk, m_clk[0]);
      end else if (out_a !== 10'(m_a) || out_b !== 10'(m_b)) begin
        n_fail++;
        $display("FAIL %s out_a=%h out_b=%h exp a=%h b=%h", cur_req, out_a, out_b,
                 10'(m_a), 10'(m_b));
      end
    end
  end

  task automatic send(input int y, input int c, input bit cv, input bit code);
    while (1) begin
      @(negedge clk);
      if (in_ready) break;
    end
    in_valid = 1'b1; in_y = 10'(y); in_c = 10'(c); in_c_valid = cv; in_code = code;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_slot();
    while (1) begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R3: parallel, values inside the limits
    cur_req = "R3"; par_mode = 1; clip_off = 0;
    for (int i = 0; i < 40; i++)
      send(64 + int'($urandom_range(0, 875)), 64 + int'($urandom_range(0, 895)), 1, 0);

    // R6 and R7: sweep both components through the full range
    cur_req = "R6";
    for (int v = 0; v < 1024; v += 7) send(v, 512, 1, 0);
    cur_req = "R7";
    for (int v = 0; v < 1024; v += 7) send(512, v, 1, 0);

    // R8: wide limits
    cur_req = "R8"; clip_off = 1;
    for (int v = 0; v < 1024; v += 5) send(v, 1023 - v, 1, 0);
    send(0, 1023, 1, 0); send(3, 1020, 1, 0); send(4, 1019, 1, 0);

    // R9: fractional bits at and beyond each limit
    cur_req = "R9"; clip_off = 0;
    send(943, 963, 1, 0); send(944, 964, 1, 0); send(63, 63, 1, 0);
    send(64, 67, 1, 0);   send(67, 960, 1, 0);

    // R10: timing words bypass clipping
    cur_req = "R10";
    send(0, 1023, 1, 1); send(1023, 0, 1, 1); send(0, 0, 1, 1); send(10'h2D8, 0, 1, 1);

    // R11: chroma invalid in parallel mode
    cur_req = "R11";
    for (int i = 0; i < 8; i++) send(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)), 0, 0);

    // R12: empty slots in both modes
    cur_req = "R12";
    idle_slot(); idle_slot(); par_mode = 0; idle_slot(); idle_slot();

    // R4: interleaved mode
    cur_req = "R4"; par_mode = 0;
    for (int i = 0; i < 60; i++)
      send(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
           1'($urandom_range(0, 1)), 1'(i % 9 == 0));
    clip_off = 1;
    for (int v = 0; v < 1024; v += 31) send(v, 1023 - v, 1, 0);

    // R13: switch mode and clip setting on every pixel
    cur_req = "R13";
    for (int i = 0; i < 40; i++) begin
      par_mode = 1'(i % 2);
      clip_off = 1'((i / 2) % 2);
      send(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)), 1, 0);
    end
    idle_slot(); idle_slot();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule